// File: doc/BRIEF.md
# IDE Programmed-I/O Strobe Timing Generator

This block produces the read or write strobe for a single programmed-I/O transfer on a two-channel IDE/ATA interface. All timing is counted in bus clocks. Each of the four attached drives has its own pair of timing codes. Drive 0 and drive 1 sit on channel 0, and drives 2 and 3 sit on channel 1. One code sets how long the strobe stays low (the active time). The other sets how long the bus then stays idle before the next transfer may start (the recovery time).

The host loads the codes through a small write port. When a transfer is requested, the block looks up the codes of the addressed drive and freezes them for that transfer. It then pulls the selected strobe low for the active time, and a low IORDY input stretches this phase. After that it lets the strobe return high for the recovery time and finally pulses `done`. Both code maps are nonlinear. Code 0 of each field maps to a long time, and the top recovery codes saturate.

Top module: `pio_strobe_gen`

## Requirements
- R1: After synchronous reset both strobes are high, `busy` and `done` are low, and every drive's codes are 0, so an unprogrammed drive runs 8 active and 12 recovery clocks.
- R2: Active code c (3 bits) gives 8 clocks for c=0, 12 clocks for c=7, and c clocks for 1..6.
- R3: Recovery code c (4 bits) gives 12 clocks for c=0, c clocks for 1..11, 13 for c=12, 14 for c=13 and 15 for both 14 and 15.
- R4: A request is accepted on a clock edge where `busy` is low. From the next cycle the read strobe (`rd_nwr`=1) or the write strobe (`rd_nwr`=0) is low for exactly the active count, and the other strobe stays high throughout.
- R5: After the active phase the strobe is high for exactly the recovery count. `done` is then high for one cycle. `busy` is high from acceptance until `done` rises.
- R6: The drive index is `req_chan`*2 + `req_unit`, and each of the four drives keeps its codes independently of the others.
- R7: With `wr_en` high, `wr_sel`=0 stores `wr_code[2:0]` as the active code of drive `wr_drive` and ignores `wr_code[3]`. `wr_sel`=1 stores `wr_code[3:0]` as its recovery code.
- R8: While `iordy` is low the active phase does not end. The strobe stays low until the first edge at which the count has run out and `iordy` is high.
- R9: A request made while `busy` is high is ignored. It starts no transfer and changes neither the strobe choice nor the timing.
- R10: The codes are captured when a request is accepted. A write during a transfer changes only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Code write strobe |
| wr_sel | input | 1 | 0 = active code, 1 = recovery code |
| wr_drive | input | 2 | Drive whose code is written |
| wr_code | input | 4 | Code value to write |
| req | input | 1 | Transfer request |
| req_chan | input | 1 | Channel of the requested drive |
| req_unit | input | 1 | Unit (master/slave) bit of the requested drive |
| rd_nwr | input | 1 | 1 = read transfer, 0 = write transfer |
| iordy | input | 1 | Device ready; low stretches the active phase |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of recovery |

## Verification
A wrong phase counter or a wrong decoded code appears directly as a strobe that is too short or too long, or as a `done` pulse in the wrong cycle. The error can be seen within one transfer of at most 27 clocks, and the bench measures both phase lengths to the exact clock. A corrupt register entry or a wrong drive index only shows when that drive is next addressed. For this reason the sweep rotates through all four drives and covers all 128 code pairs. Code capture and the blocking of requests while busy are checked by disturbing a transfer in progress and then measuring that transfer and the one that follows.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;
    localparam int CHANNELS   = 2;
    localparam int NUM_DRIVES = CHANNELS * 2;
    localparam int DRV_W      = $clog2(NUM_DRIVES);
    localparam int ACT_W      = 3;
    localparam int REC_W      = 4;
    localparam int CNT_W      = 4;

    typedef enum logic [1:0] {PH_IDLE, PH_ACT, PH_REC} phase_e;

    typedef struct packed {
        logic [ACT_W-1:0] act;
        logic [REC_W-1:0] rec;
    } tcodes_t;

    typedef struct packed {
        logic [CNT_W-1:0] act_len;
        logic [CNT_W-1:0] rec_len;
        logic             is_read;
    } cyc_cfg_t;

    function automatic logic [CNT_W-1:0] act_clocks(input logic [ACT_W-1:0] c);
        case (c)
            3'd0:    return CNT_W'(8);
            3'd7:    return CNT_W'(12);
            default: return CNT_W'(c);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] rec_clocks(input logic [REC_W-1:0] c);
        case (c)
            4'd0:          return CNT_W'(12);
            4'd12:         return CNT_W'(13);
            4'd13:         return CNT_W'(14);
            4'd14, 4'd15:  return CNT_W'(15);
            default:       return CNT_W'(c);
        endcase
    endfunction
endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DRV_W-1:0] wr_drive,
    input  logic [REC_W-1:0] wr_code,
    input  logic [DRV_W-1:0] rd_drive,
    output tcodes_t          rd_codes
);
    tcodes_t codes [NUM_DRIVES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NUM_DRIVES; d++) codes[d] <= '0;
        end else if (wr_en) begin
            if (!wr_sel) codes[wr_drive].act <= wr_code[ACT_W-1:0];
            else         codes[wr_drive].rec <= wr_code;
        end
    end

    assign rd_codes = codes[rd_drive];

    // R7
    act_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> codes[$past(wr_drive)].act == $past(wr_code[ACT_W-1:0]));
    // R7
    rec_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> codes[$past(wr_drive)].rec == $past(wr_code));
endmodule

// File: rtl/pio_cycle_seq.sv
module pio_cycle_seq
    import pio_tim_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     iordy,
    input  cyc_cfg_t cfg,
    output logic     rd_strobe_n,
    output logic     wr_strobe_n,
    output logic     busy,
    output logic     done
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rec_hold;
    logic             is_rd;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            rec_hold <= '0;
            is_rd    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: if (req) begin
                    phase    <= PH_ACT;
                    cnt      <= cfg.act_len;
                    rec_hold <= cfg.rec_len;
                    is_rd    <= cfg.is_read;
                end
                PH_ACT: begin
                    if (cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
                    else if (iordy) begin
                        phase <= PH_REC;
                        cnt   <= rec_hold;
                    end
                end
                PH_REC: begin
                    if (cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
                    else begin
                        phase  <= PH_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign rd_strobe_n = !(phase == PH_ACT && is_rd);
    assign wr_strobe_n = !(phase == PH_ACT && !is_rd);
    assign busy        = (phase != PH_IDLE);
    assign done        = done_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rd_strobe_n && wr_strobe_n && !busy && !done));
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        rd_strobe_n || wr_strobe_n);
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R5
    done_after_rec_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(phase) == PH_REC);
    // R8
    iordy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACT && cnt == CNT_W'(1) && !iordy) |=> phase == PH_ACT);
    // R9
    dir_stable_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(is_rd)));
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_tim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [DRV_W-1:0] wr_drive,
    input  logic [REC_W-1:0] wr_code,
    input  logic             req,
    input  logic             req_chan,
    input  logic             req_unit,
    input  logic             rd_nwr,
    input  logic             iordy,
    output logic             rd_strobe_n,
    output logic             wr_strobe_n,
    output logic             busy,
    output logic             done
);
    logic [DRV_W-1:0] sel_drive;
    tcodes_t          sel_codes;
    cyc_cfg_t         cfg;

    assign sel_drive = {req_chan, req_unit};

    pio_timing_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_drive (wr_drive),
        .wr_code  (wr_code),
        .rd_drive (sel_drive),
        .rd_codes (sel_codes)
    );

    always_comb begin
        cfg.act_len = act_clocks(sel_codes.act);
        cfg.rec_len = rec_clocks(sel_codes.rec);
        cfg.is_read = rd_nwr;
    end

    pio_cycle_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .iordy       (iordy),
        .cfg         (cfg),
        .rd_strobe_n (rd_strobe_n),
        .wr_strobe_n (wr_strobe_n),
        .busy        (busy),
        .done        (done)
    );
endmodule

// File: tb/pio_strobe_gen_test.sv
`timescale 1ns/1ps
module pio_strobe_gen_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_sel = 1'b0;
    logic [1:0] wr_drive = '0;
    logic [3:0] wr_code = '0;
    logic       req = 1'b0, req_chan = 1'b0, req_unit = 1'b0, rd_nwr = 1'b0;
    logic       iordy = 1'b1;
    logic       rd_strobe_n, wr_strobe_n, busy, done;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pio_strobe_gen uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_drive(wr_drive),
        .wr_code(wr_code), .req(req), .req_chan(req_chan), .req_unit(req_unit),
        .rd_nwr(rd_nwr), .iordy(iordy), .rd_strobe_n(rd_strobe_n),
        .wr_strobe_n(wr_strobe_n), .busy(busy), .done(done));

    function automatic int exp_act(input int c);
        if (c == 0) return 8;
        if (c == 7) return 12;
        return c;
    endfunction

    function automatic int exp_rec(input int c);
        if (c == 0)  return 12;
        if (c <= 11) return c;
        if (c == 12) return 13;
        if (c == 13) return 14;
        return 15;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic wr_reg(input int drv, input bit sel, input logic [3:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_drive = 2'(drv); wr_code = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // release_at = 0: iordy stays high; otherwise iordy low until that many low samples
    task automatic run_cycle(input int drv, input bit rd, input int release_at,
                             output int act_n, output int rec_n, output bit other_ok);
        @(negedge clk);
        req = 1'b1; req_chan = drv[1]; req_unit = drv[0]; rd_nwr = rd;
        iordy = (release_at > 0) ? 1'b0 : 1'b1;
        @(negedge clk);
        req = 1'b0;
        act_n = 0; rec_n = 0; other_ok = 1;
        while (((rd ? rd_strobe_n : wr_strobe_n) == 1'b0) && act_n < 100) begin
            act_n++;
            if ((rd ? wr_strobe_n : rd_strobe_n) == 1'b0) other_ok = 0;
            if (release_at > 0 && act_n >= release_at) iordy = 1'b1;
            @(negedge clk);
        end
        iordy = 1'b1;
        while (!done && rec_n < 100) begin
            rec_n++;
            if (!rd_strobe_n || !wr_strobe_n) other_ok = 0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int a_n, r_n;
        bit oth;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state at the ports
        check(rd_strobe_n && wr_strobe_n, "R1 strobes high", {rd_strobe_n, wr_strobe_n}, 3);
        check(!busy && !done, "R1 busy/done low", {busy, done}, 0);
        // R1 unprogrammed drive runs slowest timing
        run_cycle(3, 1, 0, a_n, r_n, oth);
        check(a_n == 8,  "R1 default active", a_n, 8);
        check(r_n == 12, "R1 default recovery", r_n, 12);

        // R2 R3 R4 R6 R7: full sweep over all code pairs, rotating drives
        for (int a = 0; a < 8; a++) begin
            for (int r = 0; r < 16; r++) begin
                int d;
                bit rd;
                d = (a + r) % 4;
                rd = ((a + r) / 4) % 2 == 1;
                wr_reg(d, 0, {1'b1, 3'(a)});  // R7 bit 3 ignored for active code
                wr_reg(d, 1, 4'(r));
                run_cycle(d, rd, 0, a_n, r_n, oth);
                check(a_n == exp_act(a), "R2 active length", a_n, exp_act(a));
                check(r_n == exp_rec(r), "R3 recovery length", r_n, exp_rec(r));
                check(oth, "R4 other strobe high", oth, 1);
            end
        end

        // R6 independent per-drive sets
        for (int d = 0; d < 4; d++) begin
            wr_reg(d, 0, 4'(d + 1));
            wr_reg(d, 1, 4'(d + 5));
        end
        for (int d = 3; d >= 0; d--) begin
            run_cycle(d, d[0], 0, a_n, r_n, oth);
            check(a_n == d + 1, "R6 drive active", a_n, d + 1);
            check(r_n == d + 5, "R6 drive recovery", r_n, d + 5);
        end

        // R8 iordy stretch
        wr_reg(1, 0, 4'd3);
        wr_reg(1, 1, 4'd2);
        run_cycle(1, 0, 6, a_n, r_n, oth);
        check(a_n == 6, "R8 stretched active", a_n, 6);
        check(r_n == 2, "R8 recovery after stretch", r_n, 2);
        run_cycle(1, 1, 2, a_n, r_n, oth);
        check(a_n == 3, "R8 early ready no stretch", a_n, 3);

        // R9 request while busy is ignored
        wr_reg(0, 0, 4'd6);
        wr_reg(0, 1, 4'd4);
        wr_reg(2, 0, 4'd1);
        begin
            int lows;
            bit rd_seen;
            int cnt;
            lows = 0; rd_seen = 0; cnt = 0;
            @(negedge clk);
            req = 1'b1; req_chan = 1'b0; req_unit = 1'b0; rd_nwr = 1'b0;
            @(negedge clk);
            req = 1'b1; req_chan = 1'b1; req_unit = 1'b0; rd_nwr = 1'b1;
            if (!wr_strobe_n) lows++;
            if (!rd_strobe_n) rd_seen = 1;
            @(negedge clk);
            req = 1'b0;
            while (!done && cnt < 100) begin
                cnt++;
                if (!wr_strobe_n) lows++;
                if (!rd_strobe_n) rd_seen = 1;
                @(negedge clk);
            end
            check(lows == 6, "R9 busy request kept timing", lows, 6);
            check(!rd_seen, "R9 busy request kept direction", rd_seen, 0);
            check(cnt == 9, "R9 cycle length unchanged", cnt, 9);
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(!busy && rd_strobe_n && wr_strobe_n, "R9 no deferred start", busy, 0);
            end
        end

        // R10 mid-cycle write applies only to next cycle
        wr_reg(2, 0, 4'd4);
        wr_reg(2, 1, 4'd5);
        fork
            run_cycle(2, 1, 0, a_n, r_n, oth);
            begin
                repeat (2) @(negedge clk);
                wr_en = 1'b1; wr_sel = 1'b0; wr_drive = 2'd2; wr_code = 4'd5;
                @(negedge clk);
                wr_sel = 1'b1; wr_code = 4'd9;
                @(negedge clk);
                wr_en = 1'b0;
            end
        join
        check(a_n == 4, "R10 current active kept", a_n, 4);
        check(r_n == 5, "R10 current recovery kept", r_n, 5);
        run_cycle(2, 1, 0, a_n, r_n, oth);
        check(a_n == 5, "R10 next active updated", a_n, 5);
        check(r_n == 9, "R10 next recovery updated", r_n, 9);
        // R5 busy low once done seen, strobes idle
        check(!busy, "R5 idle at done", busy, 0);

        finish_run();
    end
endmodule